// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits at the command-register front end of a word-wide NOR flash model. It watches host write cycles, each one address plus a 16-bit data word. It recognises the multi-cycle unlock handshakes that select an operation. When a handshake completes, it does one of three things:

- issues a one-cycle start strobe for word program or chip erase;
- switches into ID-read mode;
- switches into secured-sector mode.

Any cycle that does not fit the handshake sends the block back to array-read mode, and so does the active-low hardware reset.

It holds the program address and data captured from the final write of a program sequence. These stay constant for the embedded engine while that engine runs. While the engine is busy, every command write is dropped. The engine's completion pulse returns the block to array read.

The host bus carries single-cycle write strobes with no back-pressure. A write is taken in any clock cycle where `ce_n` and `we_n` are low and `oe_n` is high. The outputs are plain level and pulse signals and are never stalled.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After `rst_n` is asserted (low), `mode` is 0 (array read) and both `prog_start` and `erase_start` are low. Asserting `rst_n` at any time aborts any sequence or busy state.
- R2: A write is accepted only in a cycle with `ce_n`=0, `we_n`=0 and `oe_n`=1. Cycles with any other combination leave the decoder unchanged. The mode encoding is 0 read, 1 ID, 2 secured sector, 3 busy.
- R3: Word program takes four writes: 555/AA, then 2AA/55, then 555/A0, then any address with any data. After the fourth write, `prog_start` pulses and `mode` reads 3. `prog_addr`/`prog_data` hold that write's address and data, and all three are visible one clock after the write.
- R4: Chip erase takes six writes: 555/AA, 2AA/55, 555/80, 555/AA, 2AA/55, 555/10. `erase_start` pulses one clock after the sixth write and `mode` reads 3.
- R5: 555/AA, 2AA/55, 555/90 enters ID mode (`mode`=1). In ID mode, `id_word` is 00C2 for offset 00 and 22FD for offset 01. Every other offset gives 0000, as does any mode other than ID. ID mode survives all writes except a command byte F0.
- R6: 555/AA, 2AA/55, 555/88 enters secured-sector mode (`mode`=2). Writing 555/AA, 2AA/55, 555/90 and then data 00 at any address returns to mode 0.
- R7: A command byte F0 at any address returns the block to mode 0. This works between the cycles of a partly entered sequence and from ID or secured mode.
- R8: During a sequence, a write whose address or data differs from the expected one abandons the sequence and sets mode 0. A later fragment of that sequence then starts nothing.
- R9: While busy, all writes are ignored, F0 included. A one-cycle `op_done` returns `mode` to 0 one clock later. The latched program address and data stay constant throughout.
- R10: When `accel` is high, a single write of command byte A0 at any address enters program setup from read mode. The next write then starts a program.
- R11: Only the low 11 address bits are compared on command cycles, and only the low data byte is decoded as a command. The upper bits are don't-care.
- R12: `prog_start` and `erase_start` last exactly one cycle and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low; must be high for a write |
| addr | input | ADDR_W (21) | Write address |
| wdata | input | DATA_W (16) | Write data |
| accel | input | 1 | Accelerated-program request; skips the unlock cycles |
| op_done | input | 1 | One-cycle completion pulse from the embedded engine |
| id_ofs | input | ID_OFS_W (8) | Read offset for ID codes |
| mode | output | 2 | 0 read, 1 ID, 2 secured, 3 busy |
| prog_start | output | 1 | One-cycle program launch strobe |
| erase_start | output | 1 | One-cycle chip-erase launch strobe |
| prog_addr | output | ADDR_W (21) | Latched program address |
| prog_data | output | DATA_W (16) | Latched program data |
| id_word | output | 16 | ID code for `id_ofs` |

## Verification
Timing of each result:
- Every registered result (`mode`, the start strobes and the latched program word) is due exactly one clock after the write cycle that causes it.
- `id_word` is combinational from `id_ofs` and the current mode.

How the bench keeps to this:
- It drives each write for one full cycle starting at a falling edge.
- It samples at the next falling edge, which is the one cycle where a start strobe is high.
- It checks again one cycle later to confirm the strobe has dropped.
- After an `op_done` pulse, it checks for mode 0 at the following falling edge.
- For ID codes, it changes `id_ofs` and samples a nanosecond later, away from any clock edge.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_READ = 2'd0,
    MODE_ID   = 2'd1,
    MODE_SEC  = 2'd2,
    MODE_BUSY = 2'd3
  } mode_e;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_U1,
    SQ_U2,
    SQ_PSET,
    SQ_E80,
    SQ_EU1,
    SQ_EU2,
    SQ_XIT,
    SQ_BUSY
  } seq_e;

  // Classification of one bus cycle.
  typedef struct packed {
    logic       wr;
    logic       at_first;
    logic       at_second;
    logic [7:0] code;
  } wr_cls_t;

  localparam logic [7:0] CODE_UNLK_A = 8'hAA;
  localparam logic [7:0] CODE_UNLK_B = 8'h55;
  localparam logic [7:0] CODE_PROG   = 8'hA0;
  localparam logic [7:0] CODE_ERSU   = 8'h80;
  localparam logic [7:0] CODE_ERSC   = 8'h10;
  localparam logic [7:0] CODE_IDRD   = 8'h90;
  localparam logic [7:0] CODE_SECEN  = 8'h88;
  localparam logic [7:0] CODE_RESET  = 8'hF0;
  localparam logic [7:0] CODE_SECX   = 8'h00;

  localparam logic [11:0] ADR_FIRST  = 12'h555;
  localparam logic [11:0] ADR_SECOND = 12'h2AA;

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16,
  parameter int CMP_W  = 11
) (
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [CMP_W-1:0]  addr_lo,
  input  logic [7:0]        code,
  output wr_cls_t           cls
);
  localparam logic [CMP_W-1:0] A1 = CMP_W'(ADR_FIRST);
  localparam logic [CMP_W-1:0] A2 = CMP_W'(ADR_SECOND);

  always_comb begin
    cls.wr        = !ce_n && !we_n && oe_n;
    cls.at_first  = (addr_lo == A1);
    cls.at_second = (addr_lo == A2);
    cls.code      = code;
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  wr_cls_t cls,
  input  logic    accel,
  input  logic    op_done,
  output logic [1:0] mode,
  output logic    prog_start,
  output logic    erase_start,
  output logic    prog_load
);
  seq_e  st_q, st_d;
  mode_e base_q, base_d;
  logic  p_go, e_go;

  always_comb begin
    st_d      = st_q;
    base_d    = base_q;
    p_go      = 1'b0;
    e_go      = 1'b0;
    prog_load = 1'b0;
    if (st_q == SQ_BUSY) begin
      if (op_done) begin
        st_d   = SQ_IDLE;
        base_d = MODE_READ;
      end
    end else if (cls.wr) begin
      if (st_q == SQ_PSET) begin
        prog_load = 1'b1;
        p_go      = 1'b1;
        st_d      = SQ_BUSY;
      end else if (cls.code == CODE_RESET) begin
        st_d   = SQ_IDLE;
        base_d = MODE_READ;
      end else if (base_q == MODE_ID) begin
        st_d = SQ_IDLE;
      end else begin
        // A fall-back to read is the default outcome of any step below.
        st_d   = SQ_IDLE;
        base_d = MODE_READ;
        unique case (st_q)
          SQ_IDLE: begin
            base_d = base_q;
            if (accel && cls.code == CODE_PROG)
              st_d = SQ_PSET;
            else if (cls.at_first && cls.code == CODE_UNLK_A)
              st_d = SQ_U1;
          end
          SQ_U1: if (cls.at_second && cls.code == CODE_UNLK_B) begin
            st_d = SQ_U2; base_d = base_q;
          end
          SQ_U2: if (cls.at_first) begin
            case (cls.code)
              CODE_PROG:  begin st_d = SQ_PSET; base_d = base_q; end
              CODE_ERSU:  begin st_d = SQ_E80;  base_d = base_q; end
              CODE_IDRD: begin
                if (base_q == MODE_SEC) begin
                  st_d = SQ_XIT; base_d = base_q;
                end else begin
                  base_d = MODE_ID;
                end
              end
              CODE_SECEN: base_d = MODE_SEC;
              default: ;
            endcase
          end
          SQ_E80: if (cls.at_first && cls.code == CODE_UNLK_A) begin
            st_d = SQ_EU1; base_d = base_q;
          end
          SQ_EU1: if (cls.at_second && cls.code == CODE_UNLK_B) begin
            st_d = SQ_EU2; base_d = base_q;
          end
          SQ_EU2: if (cls.at_first && cls.code == CODE_ERSC) begin
            e_go = 1'b1; st_d = SQ_BUSY; base_d = base_q;
          end
          SQ_XIT: if (cls.code != CODE_SECX) begin
            base_d = MODE_READ;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= SQ_IDLE;
      base_q      <= MODE_READ;
      prog_start  <= 1'b0;
      erase_start <= 1'b0;
    end else begin
      st_q        <= st_d;
      base_q      <= base_d;
      prog_start  <= p_go;
      erase_start <= e_go;
    end
  end

  assign mode = (st_q == SQ_BUSY) ? MODE_BUSY : base_q;
endmodule

// File: rtl/flash_prog_latch.sv
module flash_prog_latch #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_addr <= '0;
      prog_data <= '0;
    end else if (load) begin
      prog_addr <= addr;
      prog_data <= data;
    end
  end
endmodule

// File: rtl/flash_id_rom.sv
module flash_id_rom #(
  parameter int          OFS_W    = 8,
  parameter logic [15:0] MFR_CODE = 16'h00C2,
  parameter logic [15:0] DEV_CODE = 16'h22FD
) (
  input  logic             en,
  input  logic [OFS_W-1:0] ofs,
  output logic [15:0]      word
);
  localparam int NCODE = 2;
  logic [15:0] codes [NCODE];
  assign codes[0] = MFR_CODE;
  assign codes[1] = DEV_CODE;

  always_comb begin
    word = '0;
    for (int i = 0; i < NCODE; i++)
      if (en && ofs == OFS_W'(i)) word = codes[i];
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W   = 21,
  parameter int          DATA_W   = 16,
  parameter int          CMP_W    = 11,
  parameter int          ID_OFS_W = 8,
  parameter logic [15:0] MFR_CODE = 16'h00C2,
  parameter logic [15:0] DEV_CODE = 16'h22FD
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce_n,
  input  logic                we_n,
  input  logic                oe_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                accel,
  input  logic                op_done,
  input  logic [ID_OFS_W-1:0] id_ofs,
  output logic [1:0]          mode,
  output logic                prog_start,
  output logic                erase_start,
  output logic [ADDR_W-1:0]   prog_addr,
  output logic [DATA_W-1:0]   prog_data,
  output logic [15:0]         id_word
);
  wr_cls_t cls;
  logic    load;

  flash_cmd_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(CMP_W)) u_match (
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr_lo(addr[CMP_W-1:0]), .code(wdata[7:0]), .cls(cls)
  );

  flash_cmd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cls(cls), .accel(accel), .op_done(op_done),
    .mode(mode), .prog_start(prog_start), .erase_start(erase_start),
    .prog_load(load)
  );

  flash_prog_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(load), .addr(addr), .data(wdata),
    .prog_addr(prog_addr), .prog_data(prog_data)
  );

  flash_id_rom #(.OFS_W(ID_OFS_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
    .en(mode == MODE_ID), .ofs(id_ofs), .word(id_word)
  );
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              we_n,
  input logic              oe_n,
  input logic [7:0]        code,
  input logic              op_done,
  input logic [1:0]        mode,
  input logic              prog_start,
  input logic              erase_start,
  input logic [ADDR_W-1:0] prog_addr,
  input logic [DATA_W-1:0] prog_data
);
  logic wr;
  assign wr = !ce_n && !we_n && oe_n;

  assert_excl_starts_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_start, erase_start}));

  assert_prog_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);

  assert_erase_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  assert_prog_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> mode == 2'd3);

  assert_erase_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> mode == 2'd3);

  assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !op_done) |=> mode == 2'd3);

  assert_done_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && op_done) |=> mode == 2'd0);

  assert_latch_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !prog_start && !erase_start) |-> ($stable(prog_addr) && $stable(prog_data)));

  assert_id_persist_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && !(wr && code == 8'hF0)) |=> mode == 2'd1);

  assert_no_write_no_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && mode != 2'd3) |=> $stable(mode));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .code(wdata[7:0]), .op_done(op_done), .mode(mode),
  .prog_start(prog_start), .erase_start(erase_start),
  .prog_addr(prog_addr), .prog_data(prog_data)
);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  localparam int AW = 21;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic accel = 1'b0, op_done = 1'b0;
  logic [7:0] id_ofs = '0;
  logic [1:0] mode;
  logic prog_start, erase_start;
  logic [AW-1:0] prog_addr;
  logic [DW-1:0] prog_data;
  logic [15:0] id_word;

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .accel(accel), .op_done(op_done),
    .id_ofs(id_ofs), .mode(mode), .prog_start(prog_start),
    .erase_start(erase_start), .prog_addr(prog_addr), .prog_data(prog_data),
    .id_word(id_word)
  );

  localparam logic [1:0] M_RD = 2'd0, M_ID = 2'd1, M_SEC = 2'd2, M_BSY = 2'd3;

  function automatic logic [15:0] exp_id(input logic [1:0] m, input logic [7:0] ofs);
    if (m != M_ID) return 16'h0000;
    if (ofs == 8'h00) return 16'h00C2;
    if (ofs == 8'h01) return 16'h22FD;
    return 16'h0000;
  endfunction

  function automatic logic [AW-1:0] up(input logic [10:0] lo);
    logic [AW-12:0] r;
    r = (AW-11)'($urandom());
    return {r, lo};
  endfunction

  function automatic logic [15:0] cd(input logic [7:0] c);
    logic [7:0] h;
    h = 8'($urandom());
    return {h, c};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wcyc(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic c, input logic w, input logic o);
    @(negedge clk);
    ce_n = c; we_n = w; oe_n = o; addr = a; wdata = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wcyc(a, d, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic unlock();
    wr(up(11'h555), cd(8'hAA));
    wr(up(11'h2AA), cd(8'h55));
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic finish_op(input string tag);
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
    chk(tag, mode, M_RD);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        nerr++;
        nchk++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
      end
    end
  end

  initial begin
    logic [AW-1:0] pa;
    logic [DW-1:0] pd;
    void'($urandom(32'd2024));

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 mode", mode, M_RD);
    chk("R1 strobes", {prog_start, erase_start}, 0);
    rst_n = 1'b1;
    idle();
    chk("R1 after release", mode, M_RD);

    // R2: disqualified cycles ignored
    wcyc(up(11'h555), 16'h00AA, 1'b0, 1'b0, 1'b0);
    wcyc(up(11'h2AA), 16'h0055, 1'b1, 1'b0, 1'b1);
    wcyc(up(11'h555), 16'h0090, 1'b0, 1'b1, 1'b1);
    chk("R2 disqualified", mode, M_RD);
    unlock();
    wcyc(up(11'h555), 16'h0090, 1'b0, 1'b0, 1'b0);
    chk("R2 oe low ignored", mode, M_RD);
    wr(up(11'h555), 16'h00F0);

    // R5: ID mode
    unlock();
    wr(up(11'h555), cd(8'h90));
    chk("R5 enter id", mode, M_ID);
    for (int i = 0; i < 4; i++) begin
      id_ofs = 8'(i);
      #1;
      chk("R5 id word", id_word, exp_id(mode, id_ofs));
    end
    wr(up(11'h555), cd(8'hAA));
    wr(up(11'h123), cd(8'h10));
    chk("R5 id persists", mode, M_ID);
    // R7: F0 from ID mode
    wr(up(11'h7FF), cd(8'hF0));
    chk("R7 F0 from id", mode, M_RD);
    id_ofs = 8'h01;
    #1;
    chk("R5 id word outside id", id_word, 16'h0000);

    // R3: word program
    unlock();
    wr(up(11'h555), cd(8'hA0));
    pa = 21'h1ABCDE; pd = 16'hBEEF;
    wr(pa, pd);
    chk("R3 prog_start", prog_start, 1'b1);
    chk("R3 busy", mode, M_BSY);
    chk("R3 prog_addr", prog_addr, pa);
    chk("R3 prog_data", prog_data, pd);
    idle();
    chk("R12 prog pulse one cycle", prog_start, 1'b0);
    // R9: busy ignores everything
    wr(up(11'h000), 16'h00F0);
    chk("R9 F0 ignored busy", mode, M_BSY);
    unlock();
    wr(up(11'h555), 16'h00A0);
    wr(21'h000055, 16'h1234);
    chk("R9 no restart", prog_start, 1'b0);
    chk("R9 latch held addr", prog_addr, pa);
    chk("R9 latch held data", prog_data, pd);
    finish_op("R9 done to read");

    // R4: chip erase
    unlock();
    wr(up(11'h555), cd(8'h80));
    unlock();
    wr(up(11'h555), cd(8'h10));
    chk("R4 erase_start", erase_start, 1'b1);
    chk("R12 exclusive", prog_start, 1'b0);
    chk("R4 busy", mode, M_BSY);
    idle();
    chk("R12 erase pulse one cycle", erase_start, 1'b0);
    finish_op("R4 done to read");

    // R8: wrong cycle then fragment
    wr(up(11'h555), 16'h00AA);
    wr(up(11'h2AB), 16'h0055);
    wr(up(11'h555), 16'h00A0);
    wr(21'h000100, 16'h5555);
    chk("R8 no program after wrong", prog_start, 1'b0);
    chk("R8 read mode", mode, M_RD);

    // R7: F0 between cycles
    unlock();
    wr(up(11'h555), 16'h0080);
    wr(up(11'h555), 16'h00AA);
    wr(up(11'h3C3), 16'h00F0);
    wr(up(11'h2AA), 16'h0055);
    wr(up(11'h555), 16'h0010);
    chk("R7 no erase after F0", erase_start, 1'b0);
    chk("R7 read mode", mode, M_RD);

    // R6: secured sector
    unlock();
    wr(up(11'h555), cd(8'h88));
    chk("R6 enter secure", mode, M_SEC);
    unlock();
    wr(up(11'h555), cd(8'h90));
    chk("R6 still secure", mode, M_SEC);
    wr(up(11'h0F0), 16'h0000);
    chk("R6 exit secure", mode, M_RD);

    // R10: accelerate
    accel = 1'b1;
    wr(up(11'h0C3), 16'h00A0);
    pa = 21'h0F00F0; pd = 16'h0A0A;
    wr(pa, pd);
    chk("R10 accel prog_start", prog_start, 1'b1);
    chk("R10 accel addr", prog_addr, pa);
    accel = 1'b0;
    finish_op("R10 done");
    wr(up(11'h0C3), 16'h00A0);
    wr(21'h000001, 16'h1111);
    chk("R10 no accel no start", prog_start, 1'b0);

    // R11: random programs with random upper bits
    for (int i = 0; i < 40; i++) begin
      pa = AW'($urandom());
      pd = DW'($urandom());
      unlock();
      wr(up(11'h555), cd(8'hA0));
      wr(pa, pd);
      chk("R11 random prog_start", prog_start, 1'b1);
      chk("R11 random addr", prog_addr, pa);
      chk("R11 random data", prog_data, pd);
      repeat ($urandom_range(0, 3)) idle();
      finish_op("R11 done");
    end

    // R8: random corrupted erase sequences
    for (int i = 0; i < 30; i++) begin
      automatic int bad = $urandom_range(0, 5);
      automatic logic [10:0] flip = 11'($urandom_range(1, 2047));
      logic [10:0] la [6];
      logic [7:0]  lc [6];
      la[0] = 11'h555; lc[0] = 8'hAA; la[1] = 11'h2AA; lc[1] = 8'h55;
      la[2] = 11'h555; lc[2] = 8'h80; la[3] = 11'h555; lc[3] = 8'hAA;
      la[4] = 11'h2AA; lc[4] = 8'h55; la[5] = 11'h555; lc[5] = 8'h10;
      for (int k = 0; k < 6; k++) begin
        wr(up((k == bad) ? (la[k] ^ flip) : la[k]), cd(lc[k]));
        chk("R8 no erase on corrupt", erase_start, 1'b0);
      end
      chk("R8 corrupt ends read", mode, M_RD);
    end

    // R1: reset aborts busy
    unlock();
    wr(up(11'h555), 16'h0080);
    unlock();
    wr(up(11'h555), 16'h0010);
    chk("R4 busy before reset", mode, M_BSY);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset aborts", mode, M_RD);
    rst_n = 1'b1;
    idle();

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule